// File: doc/BRIEF.md
# Edge-Triggered Event Interrupt Unit

This unit watches a vector of event lines inside a mixed-signal interface chip, for example the pen-contact detector and the converter-finished strobe. Each line has two enable bits of its own. One enable lets a low-to-high transition set that line's sticky status bit. The other does the same for a high-to-low transition. One active-high interrupt output is asserted whenever any status bit is set. Host software sees it as a rising request.

Software reaches the unit through a synchronous register port with a 16-bit data path and an 8-bit address. The status view and the clear control share one address. A read returns the latched status. A write loads a clear mask that stays in force until software writes zero. While a mask bit is held, its status bit is forced low and new edges on that line are dropped. The usual sequence is therefore "write the bits to clear, then write zero". Event lines are synchronous to the unit clock. Line 11 carries the conversion-finished event and line 12 the pen-contact event. Every line is handled identically.

Top module: `edge_irq_unit`

## Requirements
- R1: After synchronous reset, `irq_o` is 0 and addresses 0x5E, 0x60 and 0x62 all read 0x0000.
- R2: Address 0x5E holds the 16-bit rising-enable mask and 0x60 the 16-bit falling-enable mask; both read back what was written. Any other address reads 0x0000, and writes to it change no register.
- R3: If bit i of `evt_i` is sampled 1 at a rising clock edge, was 0 at the edge before, and rising-enable bit i is 1, then status bit i (bit i of 0x62) is 1 right after that edge.
- R4: A 1-to-0 transition of bit i of `evt_i` sets status bit i only when falling-enable bit i is 1.
- R5: A transition whose enable bit is 0 sets nothing. Setting the enable later does not latch a transition that has already happened.
- R6: A status bit stays set after its event line returns to its previous level, until software clears it.
- R7: A write to 0x62 clears, at that clock edge, every status bit whose position in the write data is 1. Other status bits are not affected.
- R8: While the last value written to 0x62 has bit i set, status bit i stays 0 and edges on line i are not latched. Other lines still latch normally.
- R9: Writing 0x0000 to 0x62 releases the hold at that same clock edge. An enabled edge sampled at that edge is latched.
- R10: Writing 0xFFFF and then 0x0000 to 0x62 leaves all status bits 0 and `irq_o` low.
- R11: `irq_o` is 1 exactly when at least one status bit is 1. No mask applies besides the two edge enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Unit clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 16 | Event lines, synchronous to `clk` |
| wr_en | input | 1 | Register write strobe, taken at the rising clock edge |
| addr | input | 8 | Register address for reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| irq_o | output | 1 | Active-high interrupt request |

## Verification
The hardest case to set up from the ports is an enabled edge that arrives on the very clock edge where the clear hold is released (R9). Another is an edge that arrives while the hold is still in force on that line and not on its neighbour (R8). The bench drives the release write and the event change on the same falling edge, so that both are sampled together at the following rising edge. It then reads the status back before any further change. The other cases come from a sweep over every line and every pair of enable bits, with rising and falling transitions in turn. The expected status is computed as a bit shift from the line index and the enable pair.

// File: rtl/eiu_pkg.sv
package eiu_pkg;

    localparam int EVT_W  = 16;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] ADDR_RISE = 8'h5E;
    localparam logic [ADDR_W-1:0] ADDR_FALL = 8'h60;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 8'h62;

    localparam int EVT_ADC_DONE = 11;
    localparam int EVT_PEN      = 12;

    typedef logic [EVT_W-1:0] evt_vec_t;

    typedef struct packed {
        evt_vec_t rise;
        evt_vec_t fall;
    } edges_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_RISE,
        SEL_FALL,
        SEL_STAT
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            ADDR_RISE: return SEL_RISE;
            ADDR_FALL: return SEL_FALL;
            ADDR_STAT: return SEL_STAT;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/eiu_edge_detect.sv
module eiu_edge_detect
    import eiu_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  evt_vec_t evt_i,
    output edges_t   edges
);

    evt_vec_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= evt_i;
    end

    for (genvar i = 0; i < EVT_W; i++) begin : g_bit
        assign edges.rise[i] =  evt_i[i] & ~prev_q[i];
        assign edges.fall[i] = ~evt_i[i] &  prev_q[i];
    end

endmodule

// File: rtl/eiu_regs.sv
module eiu_regs
    import eiu_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  reg_sel_e sel,
    input  evt_vec_t wdata,
    output evt_vec_t rise_en,
    output evt_vec_t fall_en,
    output evt_vec_t clr_hold,
    output evt_vec_t clr_eff
);

    logic wr_rise, wr_fall, wr_clr;

    assign wr_rise = wr_en && (sel == SEL_RISE);
    assign wr_fall = wr_en && (sel == SEL_FALL);
    assign wr_clr  = wr_en && (sel == SEL_STAT);

    // A clear write acts at its own edge; otherwise the held mask applies.
    assign clr_eff = wr_clr ? wdata : clr_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_en  <= '0;
            fall_en  <= '0;
            clr_hold <= '0;
        end else begin
            if (wr_rise) rise_en  <= wdata;
            if (wr_fall) fall_en  <= wdata;
            if (wr_clr)  clr_hold <= wdata;
        end
    end

endmodule

// File: rtl/eiu_status.sv
module eiu_status
    import eiu_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  edges_t   edges,
    input  evt_vec_t rise_en,
    input  evt_vec_t fall_en,
    input  evt_vec_t clr_eff,
    output evt_vec_t status
);

    evt_vec_t hit;

    for (genvar i = 0; i < EVT_W; i++) begin : g_bit
        assign hit[i] = (edges.rise[i] & rise_en[i]) | (edges.fall[i] & fall_en[i]);

        always_ff @(posedge clk) begin
            if (rst) status[i] <= 1'b0;
            else     status[i] <= (status[i] | hit[i]) & ~clr_eff[i];
        end
    end

endmodule

// File: rtl/edge_irq_unit.sv
module edge_irq_unit
    import eiu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [EVT_W-1:0]  evt_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [EVT_W-1:0]  wdata,
    output logic [EVT_W-1:0]  rdata,
    output logic              irq_o
);

    reg_sel_e sel;
    edges_t   edges;
    evt_vec_t rise_en_q, fall_en_q, clr_hold_q, clr_eff, status_q;

    assign sel = decode_addr(addr);

    eiu_edge_detect u_edge (
        .clk   (clk),
        .rst   (rst),
        .evt_i (evt_i),
        .edges (edges)
    );

    eiu_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .sel      (sel),
        .wdata    (wdata),
        .rise_en  (rise_en_q),
        .fall_en  (fall_en_q),
        .clr_hold (clr_hold_q),
        .clr_eff  (clr_eff)
    );

    eiu_status u_stat (
        .clk     (clk),
        .rst     (rst),
        .edges   (edges),
        .rise_en (rise_en_q),
        .fall_en (fall_en_q),
        .clr_eff (clr_eff),
        .status  (status_q)
    );

    always_comb begin
        case (sel)
            SEL_RISE: rdata = rise_en_q;
            SEL_FALL: rdata = fall_en_q;
            SEL_STAT: rdata = status_q;
            default:  rdata = '0;
        endcase
    end

    assign irq_o = |status_q;

endmodule

// File: rtl/edge_irq_unit_chk.sv
module edge_irq_unit_chk
    import eiu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [EVT_W-1:0]  evt_i,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [EVT_W-1:0]  wdata,
    input logic              irq_o,
    input logic [EVT_W-1:0]  status,
    input logic [EVT_W-1:0]  rise_en,
    input logic [EVT_W-1:0]  fall_en,
    input logic [EVT_W-1:0]  clr_hold
);

    logic [EVT_W-1:0] seen_q, en_edges, clr_now;

    always_ff @(posedge clk) begin
        if (rst) seen_q <= '0;
        else     seen_q <= evt_i;
    end

    assign en_edges = (evt_i & ~seen_q & rise_en) | (~evt_i & seen_q & fall_en);
    assign clr_now  = (wr_en && addr == ADDR_STAT) ? wdata : clr_hold;

    // R8: a held clear bit keeps its status bit low
    assert_hold_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (status & clr_hold) == '0);

    // R3 R4 R5: a status bit only becomes set after an enabled edge
    assert_set_needs_edge_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & ~$past(status) & ~$past(en_edges)) == '0));

    // R6 R7: a status bit only drops when a clear was in force
    assert_drop_needs_clear_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~status & $past(status) & ~$past(clr_now)) == '0));

    // R11: the request rises only after an enabled edge
    assert_irq_rise_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> ($past(en_edges) != '0));

    // R11: the request falls only when a clear was in force
    assert_irq_fall_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_o) |-> ($past(clr_now) != '0));

endmodule

bind edge_irq_unit edge_irq_unit_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .evt_i    (evt_i),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .irq_o    (irq_o),
    .status   (status_q),
    .rise_en  (rise_en_q),
    .fall_en  (fall_en_q),
    .clr_hold (clr_hold_q)
);

// File: tb/sim_edge_irq_unit.sv
module sim_edge_irq_unit;
    import eiu_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [EVT_W-1:0]  evt_i = '0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [EVT_W-1:0]  wdata = '0;
    logic [EVT_W-1:0]  rdata;
    logic              irq_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    edge_irq_unit u0 (
        .clk(clk), .rst(rst), .evt_i(evt_i), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
        addr = '0;
    endtask

    task automatic clear_all();
        wr(ADDR_STAT, 16'hFFFF);
        wr(ADDR_STAT, 16'h0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, exp;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", {15'd0, irq_o}, 16'h0);
        rd(ADDR_RISE, v); check("R1 rise", v, 16'h0);
        rd(ADDR_FALL, v); check("R1 fall", v, 16'h0);
        rd(ADDR_STAT, v); check("R1 stat", v, 16'h0);

        // R2 mask readback and unmapped address
        wr(ADDR_RISE, 16'hA5C3);
        wr(ADDR_FALL, 16'h3C5A);
        wr(8'h64, 16'hFFFF);
        rd(ADDR_RISE, v); check("R2 rise", v, 16'hA5C3);
        rd(ADDR_FALL, v); check("R2 fall", v, 16'h3C5A);
        rd(8'h64, v);     check("R2 unmapped", v, 16'h0);
        rd(ADDR_STAT, v); check("R2 stat untouched", v, 16'h0);

        // R3 R4 R5 R6 R11 sweep over every line and enable pair
        for (int b = 0; b < EVT_W; b++) begin
            for (int m = 0; m < 4; m++) begin
                logic [15:0] rb, fb;
                rb = ((m & 1) != 0) ? (16'h1 << b) : 16'h0;
                fb = ((m & 2) != 0) ? (16'h1 << b) : 16'h0;
                wr(ADDR_RISE, rb);
                wr(ADDR_FALL, fb);
                clear_all();
                evt_i[b] = 1'b1;
                @(negedge clk);
                rd(ADDR_STAT, v); check("R3 rise latch", v, rb);
                check("R11 irq after rise", {15'd0, irq_o}, {15'd0, rb != 0});
                evt_i[b] = 1'b0;
                @(negedge clk);
                exp = rb | fb;
                rd(ADDR_STAT, v); check("R4 R6 fall latch sticky", v, exp);
                check("R11 irq after fall", {15'd0, irq_o}, {15'd0, exp != 0});
            end
        end
        clear_all();

        // R5 edge before enabling is not latched later
        wr(ADDR_RISE, 16'h0); wr(ADDR_FALL, 16'h0);
        evt_i[5] = 1'b1;
        @(negedge clk);
        wr(ADDR_RISE, 16'h0020);
        @(negedge clk); @(negedge clk);
        rd(ADDR_STAT, v); check("R5 no retro latch", v, 16'h0);
        evt_i[5] = 1'b0; @(negedge clk);
        evt_i[5] = 1'b1; @(negedge clk);
        rd(ADDR_STAT, v); check("R5 later edge latches", v, 16'h0020);
        evt_i[5] = 1'b0;
        clear_all();

        // R10 R7 all lines set, partial clear, full clear
        wr(ADDR_RISE, 16'hFFFF);
        evt_i = 16'hFFFF;
        @(negedge clk);
        rd(ADDR_STAT, v); check("R3 all lines", v, 16'hFFFF);
        wr(ADDR_STAT, 16'h0800);
        rd(ADDR_STAT, v); check("R7 partial clear", v, 16'hF7FF);
        wr(ADDR_STAT, 16'h0000);
        check("R11 irq still set", {15'd0, irq_o}, 16'h1);
        clear_all();
        rd(ADDR_STAT, v); check("R10 full clear", v, 16'h0);
        check("R10 irq low", {15'd0, irq_o}, 16'h0);
        evt_i = '0;
        @(negedge clk);

        // R8 held clear blocks one line, not its neighbour
        wr(ADDR_RISE, 16'hFFFF);
        wr(ADDR_FALL, 16'h0000);
        wr(ADDR_STAT, 16'h1 << EVT_PEN);
        evt_i[EVT_PEN] = 1'b1;
        evt_i[EVT_ADC_DONE] = 1'b1;
        @(negedge clk);
        rd(ADDR_STAT, v); check("R8 hold blocks pen line", v, 16'h1 << EVT_ADC_DONE);
        wr(ADDR_STAT, 16'h0000);
        rd(ADDR_STAT, v); check("R8 release keeps other", v, 16'h1 << EVT_ADC_DONE);
        evt_i[EVT_PEN] = 1'b0; @(negedge clk);
        evt_i[EVT_PEN] = 1'b1; @(negedge clk);
        rd(ADDR_STAT, v); check("R8 latches after release", v, 16'h1800);
        evt_i = '0;
        clear_all();

        // R9 edge on the same clock edge as the release write
        wr(ADDR_STAT, 16'h0008);
        wr_en = 1'b1; addr = ADDR_STAT; wdata = 16'h0000; evt_i[3] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; addr = '0;
        rd(ADDR_STAT, v); check("R9 edge at release", v, 16'h0008);
        check("R11 irq at release", {15'd0, irq_o}, 16'h1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule